// File: doc/BRIEF.md
# Converter Power-Down and Start-Up Sequencer

This block brings a stereo converter's digital back end out of power-down. An active-low power-down input holds the decimation filter in reset and forces both channel outputs to two's-complement zero. The zero forcing takes effect at once, without waiting for a clock. When the input is released, it passes through a two-flop synchronizer in the master-clock domain. The sequencer then starts an initialization count measured in word-clock (frame) periods. The count is 4132 frames when the converter is a clock slave and 4129 when it is the clock master. The ready flag rises at the end of the count, and from then on the sample outputs pass the filter's data through.

As a slave, the sequencer stays in power-down until the first frame-start edge of the word clock arrives. That edge is rising in left-justified format and falling in I2S format. As a master, it starts counting as soon as the released power-down input has crossed the synchronizer, without waiting for any word-clock edge. The word clock reaches the block as two one-cycle pulses, one for each edge direction, already in the master-clock domain. Taking power-down low again at any point restarts the whole sequence.

Top module: `pdseq_top`

## Requirements
- R1: While `pdnN` is 0, `forceZero` and `filtReset` are 1, and `dataReady`, `outL` and `outR` are 0. These values take effect with no clock edge in between.
- R2: In slave mode (`masterMode`=0), `filtReset` stays 1 after release until a frame-start pulse arrives. The frame-start pulse is `lrckRise` when `i2sFormat`=0 and `lrckFall` when `i2sFormat`=1. A pulse of the other polarity is ignored.
- R3: In slave mode, `dataReady` becomes 1 in the cycle after the 4132nd frame-start pulse is sampled, counting the pulse that ended the wait as the first.
- R4: In master mode (`masterMode`=1), `filtReset` falls within three `mclk` edges of release with no pulse needed. `dataReady` becomes 1 in the cycle after the 4129th frame-start pulse sampled after that point.
- R5: Throughout initialization, `outL` and `outR` are 0 and `dataReady` is 0, whatever `sampleL`/`sampleR` carry.
- R6: While `dataReady` is 1, `outL` equals `sampleL` and `outR` equals `sampleR`.
- R7: Driving `pdnN` low during initialization, including in the same cycle as the final frame-start pulse, aborts the sequence. A later release starts the full count again.
- R8: Once 1, `dataReady` stays 1 until `pdnN` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| pdnN | input | 1 | Power-down and reset, active low, asynchronous |
| lrckRise | input | 1 | One-cycle pulse on a word-clock rising edge |
| lrckFall | input | 1 | One-cycle pulse on a word-clock falling edge |
| masterMode | input | 1 | 1 = block is clock master, 0 = slave |
| i2sFormat | input | 1 | 1 = I2S framing, 0 = left-justified |
| sampleL | input | DATA_W | Left sample from the filter |
| sampleR | input | DATA_W | Right sample from the filter |
| filtReset | output | 1 | Holds the decimation filter in reset |
| forceZero | output | 1 | Sample outputs forced to zero |
| dataReady | output | 1 | Output data valid |
| outL | output | DATA_W | Left sample out, zero until ready |
| outR | output | DATA_W | Right sample out, zero until ready |

## Verification
The final frame-start pulse that would end initialization can arrive in the same cycle as a new power-down assertion. The bench provokes this by driving the last counted pulse and pulling `pdnN` low in the same half-cycle. It judges the result by `dataReady` staying 0 and `forceZero` reading 1. A full-length run after the next release must then again need the whole count before ready appears.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;
  typedef enum logic [1:0] {
    IDLE_PD    = 2'd0,
    WAIT_EDGE  = 2'd1,
    INIT_COUNT = 2'd2,
    RUN        = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic cntClear;
    logic cntLoadOne;
    logic cntInc;
  } cnt_strobe_t;
endpackage

// File: rtl/pdseq_ctrl.sv
module pdseq_ctrl
  import pdseq_pkg::*;
(
  input  logic        mclk,
  input  logic        pdnN,
  input  logic        lrckRise,
  input  logic        lrckFall,
  input  logic        masterMode,
  input  logic        i2sFormat,
  input  logic        cntLast,
  output cnt_strobe_t strb,
  output logic        filtReset,
  output logic        forceZero,
  output logic        dataReady
);
  logic       pdnMeta, pdnSync;
  logic       startEdge;
  seq_state_e state, stateNext;

  // two-flop synchronizer: assertion is asynchronous, release is synchronized
  always_ff @(posedge mclk or negedge pdnN) begin
    if (!pdnN) begin
      pdnMeta <= 1'b0;
      pdnSync <= 1'b0;
    end else begin
      pdnMeta <= 1'b1;
      pdnSync <= pdnMeta;
    end
  end

  assign startEdge = i2sFormat ? lrckFall : lrckRise;

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      IDLE_PD: begin
        if (pdnSync) begin
          if (masterMode) begin
            stateNext     = INIT_COUNT;
            strb.cntClear = 1'b1;
          end else begin
            stateNext = WAIT_EDGE;
          end
        end
      end
      WAIT_EDGE: begin
        if (startEdge) begin
          stateNext       = INIT_COUNT;
          strb.cntLoadOne = 1'b1;
        end
      end
      INIT_COUNT: begin
        if (startEdge) begin
          if (cntLast) stateNext = RUN;
          else         strb.cntInc = 1'b1;
        end
      end
      RUN: stateNext = RUN;
      default: stateNext = IDLE_PD;
    endcase
    if (!pdnSync) stateNext = IDLE_PD;
  end

  always_ff @(posedge mclk or negedge pdnN) begin
    if (!pdnN) state <= IDLE_PD;
    else       state <= stateNext;
  end

  assign filtReset = (state == IDLE_PD) || (state == WAIT_EDGE);
  assign dataReady = (state == RUN) && pdnN;
  assign forceZero = !dataReady;
endmodule

// File: rtl/pdseq_datapath.sv
module pdseq_datapath
  import pdseq_pkg::*;
#(
  parameter int SLAVE_CYCLES  = 4132,
  parameter int MASTER_CYCLES = 4129,
  parameter int DATA_W        = 24
) (
  input  logic              mclk,
  input  logic              pdnN,
  input  cnt_strobe_t       strb,
  input  logic              masterMode,
  input  logic              forceZero,
  input  logic [DATA_W-1:0] sampleL,
  input  logic [DATA_W-1:0] sampleR,
  output logic              cntLast,
  output logic [DATA_W-1:0] outL,
  output logic [DATA_W-1:0] outR
);
  localparam int MAX_CYCLES = (SLAVE_CYCLES > MASTER_CYCLES) ? SLAVE_CYCLES : MASTER_CYCLES;
  localparam int CNT_W      = $clog2(MAX_CYCLES + 1);
  localparam logic [CNT_W-1:0] SLAVE_LAST  = CNT_W'(SLAVE_CYCLES - 1);
  localparam logic [CNT_W-1:0] MASTER_LAST = CNT_W'(MASTER_CYCLES - 1);

  logic [CNT_W-1:0] frameCnt;

  always_ff @(posedge mclk or negedge pdnN) begin
    if (!pdnN)                frameCnt <= '0;
    else if (strb.cntClear)   frameCnt <= '0;
    else if (strb.cntLoadOne) frameCnt <= CNT_W'(1);
    else if (strb.cntInc)     frameCnt <= frameCnt + CNT_W'(1);
  end

  assign cntLast = (frameCnt == (masterMode ? MASTER_LAST : SLAVE_LAST));

  logic [1:0][DATA_W-1:0] chanIn, chanOut;
  assign chanIn = {sampleR, sampleL};

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    assign chanOut[ch] = forceZero ? '0 : chanIn[ch];
  end

  assign outL = chanOut[0];
  assign outR = chanOut[1];
endmodule

// File: rtl/pdseq_top.sv
module pdseq_top
  import pdseq_pkg::*;
#(
  parameter int SLAVE_CYCLES  = 4132,
  parameter int MASTER_CYCLES = 4129,
  parameter int DATA_W        = 24
) (
  input  logic              mclk,
  input  logic              pdnN,
  input  logic              lrckRise,
  input  logic              lrckFall,
  input  logic              masterMode,
  input  logic              i2sFormat,
  input  logic [DATA_W-1:0] sampleL,
  input  logic [DATA_W-1:0] sampleR,
  output logic              filtReset,
  output logic              forceZero,
  output logic              dataReady,
  output logic [DATA_W-1:0] outL,
  output logic [DATA_W-1:0] outR
);
  cnt_strobe_t strb;
  logic        cntLast;

  pdseq_ctrl u_ctrl (
    .mclk(mclk), .pdnN(pdnN), .lrckRise(lrckRise), .lrckFall(lrckFall),
    .masterMode(masterMode), .i2sFormat(i2sFormat), .cntLast(cntLast),
    .strb(strb), .filtReset(filtReset), .forceZero(forceZero), .dataReady(dataReady)
  );

  pdseq_datapath #(
    .SLAVE_CYCLES(SLAVE_CYCLES), .MASTER_CYCLES(MASTER_CYCLES), .DATA_W(DATA_W)
  ) u_dp (
    .mclk(mclk), .pdnN(pdnN), .strb(strb), .masterMode(masterMode),
    .forceZero(forceZero), .sampleL(sampleL), .sampleR(sampleR),
    .cntLast(cntLast), .outL(outL), .outR(outR)
  );
endmodule

// File: rtl/pdseq_checker.sv
module pdseq_checker #(
  parameter int DATA_W = 24
) (
  input logic              mclk,
  input logic              pdnN,
  input logic              lrckRise,
  input logic              lrckFall,
  input logic              masterMode,
  input logic              i2sFormat,
  input logic [DATA_W-1:0] sampleL,
  input logic [DATA_W-1:0] sampleR,
  input logic              filtReset,
  input logic              forceZero,
  input logic              dataReady,
  input logic [DATA_W-1:0] outL,
  input logic [DATA_W-1:0] outR
);
  logic frameStart;
  assign frameStart = i2sFormat ? lrckFall : lrckRise;

  always_comb begin
    if (!pdnN) begin
      AST_PD_FORCES_ZERO: assert (forceZero && !dataReady); // R1
    end
  end

  AST_SLAVE_WAKE_ON_EDGE: assert property (@(posedge mclk) disable iff (!pdnN)
    ($fell(filtReset) && !masterMode) |-> $past(frameStart)); // R2

  AST_READY_ON_EDGE: assert property (@(posedge mclk) disable iff (!pdnN)
    $rose(dataReady) |-> $past(frameStart)); // R3

  AST_ZERO_UNTIL_READY: assert property (@(posedge mclk) disable iff (!pdnN)
    !dataReady |-> (outL == '0 && outR == '0)); // R5

  AST_PASS_WHEN_READY: assert property (@(posedge mclk) disable iff (!pdnN)
    dataReady |-> (outL == sampleL && outR == sampleR)); // R6

  AST_READY_STICKY: assert property (@(posedge mclk) disable iff (!pdnN)
    dataReady |=> dataReady); // R8

  AST_NO_READY_IN_RESET: assert property (@(posedge mclk) disable iff (!pdnN)
    filtReset |-> !dataReady); // R1
endmodule

bind pdseq_top pdseq_checker #(.DATA_W(DATA_W)) u_chk (
  .mclk(mclk), .pdnN(pdnN), .lrckRise(lrckRise), .lrckFall(lrckFall),
  .masterMode(masterMode), .i2sFormat(i2sFormat), .sampleL(sampleL),
  .sampleR(sampleR), .filtReset(filtReset), .forceZero(forceZero),
  .dataReady(dataReady), .outL(outL), .outR(outR)
);

// File: tb/tb_pdseq_top.sv
module tb_pdseq_top;
  localparam int NS = 4132;
  localparam int NM = 4129;
  localparam int DW = 24;

  logic          clk = 1'b0;
  logic          pdnN = 1'b0;
  logic          lrckRise = 1'b0, lrckFall = 1'b0;
  logic          masterMode = 1'b0, i2sFormat = 1'b0;
  logic [DW-1:0] sampleL = '0, sampleR = '0;
  logic          filtReset, forceZero, dataReady;
  logic [DW-1:0] outL, outR;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pdseq_top #(.SLAVE_CYCLES(NS), .MASTER_CYCLES(NM), .DATA_W(DW)) dut (
    .mclk(clk), .pdnN(pdnN), .lrckRise(lrckRise), .lrckFall(lrckFall),
    .masterMode(masterMode), .i2sFormat(i2sFormat), .sampleL(sampleL),
    .sampleR(sampleR), .filtReset(filtReset), .forceZero(forceZero),
    .dataReady(dataReady), .outL(outL), .outR(outR)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse(input bit rise);
    @(negedge clk);
    lrckRise = rise;
    lrckFall = !rise;
    @(negedge clk);
    lrckRise = 1'b0;
    lrckFall = 1'b0;
  endtask

  // power-down entry, checked without any clock edge
  task automatic enterPowerDown(input string req);
    @(negedge clk);
    pdnN = 1'b0;
    #1;
    check(forceZero && filtReset && !dataReady && outL == '0 && outR == '0, req,
          "pd outputs fz/fr/rdy/outL", {forceZero, filtReset, dataReady, outL},
          {3'b110, {DW{1'b0}}});
    repeat (40) @(negedge clk);
  endtask

  // full sequence; abortLast pulls pdnN low together with the final pulse
  task automatic runSeq(input bit master, input bit i2s, input bit abortLast);
    int n;
    bit qualRise;
    string rq;
    n = master ? NM : NS;
    rq = master ? "R4" : "R3";
    qualRise = !i2s;
    masterMode = master;
    i2sFormat = i2s;
    @(negedge clk);
    pdnN = 1'b1;
    repeat (5) @(negedge clk);
    if (master) begin
      check(filtReset == 1'b0, "R4", "master filtReset after release", filtReset, 1'b0);
    end else begin
      check(filtReset == 1'b1, "R2", "slave filtReset before edge", filtReset, 1'b1);
      pulse(!qualRise); // other polarity: ignored
      @(negedge clk);
      check(filtReset == 1'b1, "R2", "filtReset after wrong-polarity edge", filtReset, 1'b1);
    end
    for (int q = 1; q <= n; q++) begin
      sampleL = DW'(q * 37 + 5);
      sampleR = DW'(q * 91 + 3);
      @(negedge clk);
      lrckRise = qualRise;
      lrckFall = !qualRise;
      if (abortLast && q == n) pdnN = 1'b0;
      @(negedge clk);
      lrckRise = 1'b0;
      lrckFall = 1'b0;
      if (abortLast && q == n) begin
        check(!dataReady && forceZero, "R7", "ready after coincident pd", dataReady, 1'b0);
        repeat (40) @(negedge clk);
        return;
      end
      if (q < n) begin
        if (q == 1 || q == n - 1 || (q % 512) == 0)
          check(!dataReady && outL == '0 && outR == '0 && !filtReset, "R5",
                "init rdy/outL", {dataReady, outL}, 0);
        else if (dataReady || outL != '0 || outR != '0)
          check(1'b0, "R5", "init rdy/outL", {dataReady, outL}, 0);
      end else begin
        check(dataReady == 1'b1, rq, "ready after final edge", dataReady, 1'b1);
        check(outL == sampleL && outR == sampleR, "R6", "pass-through L",
              outL, sampleL);
      end
      pulse(!qualRise);
      @(negedge clk);
    end
    repeat (8) @(negedge clk);
    check(dataReady == 1'b1, "R8", "ready held", dataReady, 1'b1);
    sampleL = 24'hABCDEF;
    sampleR = 24'h123456;
    #1;
    check(outL == 24'hABCDEF && outR == 24'h123456, "R6", "pass-through R", outR, 24'h123456);
    enterPowerDown("R1");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(forceZero && filtReset && !dataReady && outL == '0, "R1", "reset state",
          {forceZero, filtReset, dataReady}, 3'b110);
    runSeq(1'b0, 1'b0, 1'b1);   // R7 abort on final edge
    runSeq(1'b0, 1'b0, 1'b0);   // R7 restart must need full count
    runSeq(1'b0, 1'b1, 1'b0);
    runSeq(1'b1, 1'b0, 1'b0);
    runSeq(1'b1, 1'b1, 1'b0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule